// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block drives a byte-level two-wire bus master on behalf of a data mover. It takes a start address, a byte count and a direction. For a write it drains bytes from a FIFO into a serial EEPROM and cuts the transfer into transactions that each stay inside one device page. For a read it performs a random read and streams the returned bytes out.

The byte master below it handles all bit timing. The sequencer issues one command at a time to the master: START, WRITE of a byte, READ of a byte, or STOP. It then waits for the master's completion pulse, which reports the acknowledge bit received on writes and the byte received on reads.

After each page write the device needs time to commit the data internally. Depending on a parameter, the sequencer either waits a fixed number of cycles or keeps addressing the device until it answers with ACK. An unexpected NACK ends the operation cleanly and reports how far the transfer had got.

Top module: `eeprom_page_seq`

## Requirements
- R1: A write transaction is START, the device byte {DEV_ADDR, 0}, the memory address (high byte first and only when AW > 8, then the low byte), the data bytes in FIFO order, then STOP.
- R2: No write transaction crosses a page. The first chunk holds PAGE − (address mod PAGE) bytes, capped at the count. Later chunks hold a full page or whatever remains.
- R3: A data byte is offered to the master only while the FIFO is not empty. Exactly one FIFO pop happens per data byte completed.
- R4: With POLL_MODE = 0, at least WR_WAIT_CYC cycles pass between the STOP that ends a page and the next START.
- R5: With POLL_MODE = 1, after each page the block repeats START plus the device write byte, closing each attempt with STOP, until the device ACKs. On that ACK it goes straight on to the next memory address. After the final page it instead issues STOP.
- R6: A read is START, {DEV_ADDR, 0}, the address bytes, a repeated START, {DEV_ADDR, 1}, then count READ commands. Only the last READ carries the NACK flag, and STOP follows it.
- R7: Each byte read appears on rd_data with rd_valid high one cycle after the master's completion, in address order.
- R8: A NACK in any address or data phase outside polling causes the following:
  - err is set;
  - err_offset records the number of data bytes already completed in the operation;
  - STOP is issued and the block returns to idle.
  err clears when the next operation is accepted.
- R9: op_ready is high only when idle, and no bus command is issued while idle. An operation with a count of zero is accepted and causes no bus activity.
- R10: Once raised, bm_cmd_valid and the command fields stay stable until bm_done.
- R11: After reset: op_ready = 1, bm_cmd_valid = 0, err = 0, rd_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Sequencer idle and able to take an operation |
| op_read | input | 1 | 1 = random read, 0 = FIFO-fed write |
| op_addr | input | AW | Start memory address |
| op_count | input | CW | Number of bytes |
| fifo_empty | input | 1 | Source FIFO has no data (first-word fall-through) |
| fifo_data | input | 8 | Head byte of source FIFO |
| fifo_pop | output | 1 | Consume the head byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| bm_cmd_valid | output | 1 | Command to byte master pending |
| bm_cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| bm_cmd_wdata | output | 8 | Byte to write |
| bm_cmd_nack | output | 1 | Answer this READ with NACK |
| bm_done | input | 1 | Command completed (one-cycle pulse) |
| bm_ack | input | 1 | ACK seen on a WRITE |
| bm_rdata | input | 8 | Byte returned by a READ |
| err | output | 1 | Operation aborted on NACK |
| err_offset | output | CW | Data bytes completed before the abort |

## Verification
Every bus result is tied to the master's completion pulse, and the bench models the master with a fixed two-cycle latency. Read bytes are due one cycle after each completion. The bench captures them on the falling edge, so the strobe and its data are both settled when sampled. Memory contents, transaction counts, pop counts and the STOP-to-START gap are judged only after op_ready returns high, when every command of the operation has completed. The error flag and offset are sampled at that same point.

// File: rtl/eps_pkg.sv
package eps_pkg;
   typedef enum logic [1:0] {
      BM_START = 2'd0,
      BM_WRITE = 2'd1,
      BM_READ  = 2'd2,
      BM_STOP  = 2'd3
   } bm_op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_DEVW, S_AHI, S_ALO,
      S_RSTART, S_DEVR, S_READ, S_DATA, S_STOP, S_WAIT
   } seq_state_e;
endpackage

// File: rtl/eps_chunk_calc.sv
module eps_chunk_calc #(
   parameter int AW   = 9,
   parameter int CW   = 8,
   parameter int PAGE = 16
) (
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] remain,
   output logic [CW-1:0] len
);
   localparam int PW = $clog2(PAGE);
   localparam int MW = (CW > PW + 1) ? CW : PW + 1;

   if (PAGE < 2 || (PAGE & (PAGE - 1)) != 0) begin : g_bad_page
      $error("PAGE must be a power of two of at least 2");
   end
   if (AW < PW) begin : g_bad_aw
      $error("AW must cover one page");
   end

   logic [MW-1:0] room;
   logic [MW-1:0] rem_x;

   assign room  = MW'(PAGE) - MW'(addr[PW-1:0]);
   assign rem_x = MW'(remain);
   assign len   = CW'((rem_x < room) ? rem_x : room);
endmodule

// File: rtl/eps_wait_timer.sv
module eps_wait_timer #(
   parameter bit USE_TIMER   = 1'b1,
   parameter int WR_WAIT_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   if (WR_WAIT_CYC < 1) begin : g_bad_wait
      $error("WR_WAIT_CYC must be at least 1");
   end

   if (USE_TIMER) begin : g_timer
      localparam int CNTW = $clog2(WR_WAIT_CYC + 1);
      logic [CNTW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (start)      cnt <= CNTW'(WR_WAIT_CYC);
         else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign expired = (cnt == '0);
   end else begin : g_no_timer
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, start};
      assign expired   = 1'b1;
   end
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
   import eps_pkg::*;
#(
   parameter int          AW          = 9,
   parameter int          CW          = 8,
   parameter int          PAGE        = 16,
   parameter logic [6:0]  DEV_ADDR    = 7'h50,
   parameter int unsigned POLL_MODE   = 0,
   parameter int          WR_WAIT_CYC = 5000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   output logic          op_ready,
   input  logic          op_read,
   input  logic [AW-1:0] op_addr,
   input  logic [CW-1:0] op_count,
   input  logic          fifo_empty,
   input  logic [7:0]    fifo_data,
   output logic          fifo_pop,
   output logic          rd_valid,
   output logic [7:0]    rd_data,
   output logic          bm_cmd_valid,
   output logic [1:0]    bm_cmd_op,
   output logic [7:0]    bm_cmd_wdata,
   output logic          bm_cmd_nack,
   input  logic          bm_done,
   input  logic          bm_ack,
   input  logic [7:0]    bm_rdata,
   output logic          err,
   output logic [CW-1:0] err_offset
);
   localparam int PW = $clog2(PAGE);
   localparam seq_state_e ADDR_FIRST = (AW > 8) ? S_AHI : S_ALO;

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 1..16");
   end
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end

   seq_state_e    state;
   logic [AW-1:0] cur_addr;
   logic [CW-1:0] rem, left, offset, chunk_len;
   logic          rd_mode, polling, closing, aborting;
   logic [7:0]    a_hi, a_lo;
   logic          nack_fail, tmr_start, tmr_expired;

   // address bytes: a high byte exists only for wide addresses
   if (AW > 8) begin : g_two_abytes
      assign a_hi = 8'(cur_addr >> 8);
   end else begin : g_one_abyte
      assign a_hi = 8'h00;
   end
   assign a_lo = 8'(cur_addr);

   eps_chunk_calc #(.AW(AW), .CW(CW), .PAGE(PAGE)) u_chunk (
      .addr(cur_addr), .remain(rem), .len(chunk_len));

   eps_wait_timer #(.USE_TIMER(POLL_MODE == 0), .WR_WAIT_CYC(WR_WAIT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .expired(tmr_expired));

   // command presented to the byte master
   always_comb begin
      bm_cmd_valid = 1'b0;
      bm_cmd_op    = BM_STOP;
      bm_cmd_wdata = 8'h00;
      bm_cmd_nack  = 1'b0;
      case (state)
         S_START, S_RSTART: begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_START; end
         S_DEVW: begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_WRITE; bm_cmd_wdata = {DEV_ADDR, 1'b0}; end
         S_AHI:  begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_WRITE; bm_cmd_wdata = a_hi; end
         S_ALO:  begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_WRITE; bm_cmd_wdata = a_lo; end
         S_DEVR: begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_WRITE; bm_cmd_wdata = {DEV_ADDR, 1'b1}; end
         S_READ: begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_READ; bm_cmd_nack = (rem == CW'(1)); end
         S_DATA: begin bm_cmd_valid = !fifo_empty; bm_cmd_op = BM_WRITE; bm_cmd_wdata = fifo_data; end
         S_STOP: begin bm_cmd_valid = 1'b1; bm_cmd_op = BM_STOP; end
         default: ;
      endcase
   end

   assign op_ready  = (state == S_IDLE);
   assign fifo_pop  = (state == S_DATA) && bm_done;
   assign nack_fail = bm_done && !bm_ack &&
                      ((state == S_DEVW && !polling) || state == S_AHI || state == S_ALO ||
                       state == S_DEVR || state == S_DATA);
   assign tmr_start = (state == S_STOP) && bm_done && !aborting && !rd_mode && !closing && !polling;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; cur_addr <= '0; rem <= '0; left <= '0; offset <= '0;
         rd_mode <= 1'b0; polling <= 1'b0; closing <= 1'b0; aborting <= 1'b0;
         err <= 1'b0; err_offset <= '0; rd_valid <= 1'b0; rd_data <= 8'h00;
      end else begin
         rd_valid <= (state == S_READ) && bm_done;
         if (bm_done) rd_data <= bm_rdata;
         if (nack_fail) begin
            err        <= 1'b1;
            err_offset <= offset;
            aborting   <= 1'b1;
            state      <= S_STOP;
         end else begin
            case (state)
               S_IDLE: if (op_valid) begin
                  err <= 1'b0;
                  if (op_count != '0) begin
                     cur_addr <= op_addr; rem <= op_count; offset <= '0;
                     rd_mode <= op_read; polling <= 1'b0; closing <= 1'b0; aborting <= 1'b0;
                     state <= S_START;
                  end
               end
               S_START:  if (bm_done) state <= S_DEVW;
               S_DEVW:   if (bm_done) begin
                  if (!bm_ack)             state <= S_STOP;
                  else if (polling && rem == '0) begin closing <= 1'b1; state <= S_STOP; end
                  else begin polling <= 1'b0; state <= ADDR_FIRST; end
               end
               S_AHI:    if (bm_done) state <= S_ALO;
               S_ALO:    if (bm_done) begin
                  if (rd_mode) state <= S_RSTART;
                  else begin left <= chunk_len; state <= S_DATA; end
               end
               S_RSTART: if (bm_done) state <= S_DEVR;
               S_DEVR:   if (bm_done) state <= S_READ;
               S_READ:   if (bm_done) begin
                  rem <= rem - 1'b1; cur_addr <= cur_addr + 1'b1; offset <= offset + 1'b1;
                  if (rem == CW'(1)) state <= S_STOP;
               end
               S_DATA:   if (bm_done) begin
                  rem <= rem - 1'b1; cur_addr <= cur_addr + 1'b1;
                  offset <= offset + 1'b1; left <= left - 1'b1;
                  if (left == CW'(1)) state <= S_STOP;
               end
               S_STOP:   if (bm_done) begin
                  if (aborting || rd_mode || closing) state <= S_IDLE;
                  else if (polling)                   state <= S_START;
                  else if (POLL_MODE != 0) begin polling <= 1'b1; state <= S_START; end
                  else                                state <= S_WAIT;
               end
               S_WAIT:   if (tmr_expired) state <= (rem == '0) ? S_IDLE : S_START;
               default:  state <= S_IDLE;
            endcase
         end
      end
   end

   // R10: a command stays put until the master completes it
   a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      bm_cmd_valid && !bm_done |=> bm_cmd_valid && $stable(bm_cmd_op) && $stable(bm_cmd_wdata));
   // R3: never consume from an empty FIFO
   a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);
   // R9: idle means a quiet bus
   a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      op_ready |-> !bm_cmd_valid);
   // R8: a raised error is followed by STOP on the bus
   a_r8_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> bm_cmd_valid && bm_cmd_op == BM_STOP);
   // R2: the last byte of a page closes its chunk
   a_r2_page_end: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_DATA && bm_done && bm_ack && cur_addr[PW-1:0] == '1 |-> left == CW'(1));
   // R7: read strobe follows a completion by one cycle
   a_r7_rd_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bm_done));
endmodule

// File: tb/eeprom_page_seq_tb.sv
module tb_eeprom_model #(
   parameter int         AW       = 9,
   parameter int         PAGE     = 8,
   parameter logic [6:0] DEV      = 7'h50,
   parameter int         BUSY_CYC = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic [7:0] cmd_wdata,
   input  logic       cmd_nack,
   input  logic       fifo_pop,
   output logic       done,
   output logic       ack,
   output logic [7:0] rdata,
   output logic       fifo_empty,
   output logic [7:0] fifo_data
);
   localparam int MEMSZ = 1 << AW;
   logic [7:0] mem [MEMSZ];
   int seed = 0, push_limit = 0, pushed = 0, popped = 0, avail = 0;
   int force_nack_idx = -1, data_cnt = 0;
   int txn_wr = 0, cross_err = 0, busy_nacks = 0, bad_nack = 0, proto_err = 0, cmd_cnt = 0;
   int min_gap = 1000000000;
   int wr_busy = 0, ph = 5, ptr = 0, txn_start = 0, txn_len = 0, stop_cyc = 0, cyc = 0, lat = 0;
   bit active = 0, gap_pend = 0, prev_rd = 0, prev_rd_nack = 0;

   initial for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hEE;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0; ack <= 1'b0; rdata <= 8'h00; fifo_empty <= 1'b1; fifo_data <= 8'h00;
         active = 0; lat = 0;
      end else begin
         cyc++;
         if (wr_busy > 0) wr_busy--;
         if (fifo_pop) begin popped++; avail--; end
         if ((cyc % 3) == 0 && avail < 2 && pushed < push_limit) begin avail++; pushed++; end
         fifo_empty <= (avail == 0);
         fifo_data  <= 8'(seed + popped * 7);
         if (active && !done && !cmd_valid) proto_err++;
         done <= 1'b0;
         if (cmd_valid && !active) begin
            active = 1; lat = 2; cmd_cnt++;
            if (prev_rd_nack && cmd_op != 2'd3) bad_nack++;
            if (cmd_op == 2'd3 && prev_rd && !prev_rd_nack) bad_nack++;
            prev_rd      = (cmd_op == 2'd2);
            prev_rd_nack = (cmd_op == 2'd2) && cmd_nack;
            case (cmd_op)
               2'd0: begin
                  if (gap_pend) begin
                     if (cyc - stop_cyc < min_gap) min_gap = cyc - stop_cyc;
                     gap_pend = 0;
                  end
                  ph = 0; txn_len = 0; ack <= 1'b1;
               end
               2'd1: begin
                  case (ph)
                     0: if (cmd_wdata[7:1] == DEV && wr_busy == 0) begin
                           ack <= 1'b1;
                           ph = cmd_wdata[0] ? 4 : ((AW > 8) ? 1 : 2);
                        end else begin
                           ack <= 1'b0;
                           if (wr_busy > 0) busy_nacks++;
                           ph = 5;
                        end
                     1: begin ptr = (int'(cmd_wdata) << 8) & (MEMSZ - 1); ph = 2; ack <= 1'b1; end
                     2: begin
                           ptr = ((ptr & ~255) | int'(cmd_wdata)) & (MEMSZ - 1);
                           txn_start = ptr; ph = 3; ack <= 1'b1;
                        end
                     3: if (data_cnt == force_nack_idx) begin
                           ack <= 1'b0; ph = 5;
                        end else begin
                           mem[ptr] = cmd_wdata;
                           ptr = (ptr & ~(PAGE - 1)) | ((ptr + 1) & (PAGE - 1));
                           txn_len++; data_cnt++; ack <= 1'b1;
                        end
                     default: ack <= 1'b0;
                  endcase
               end
               2'd2: begin rdata <= mem[ptr]; ptr = (ptr + 1) % MEMSZ; ack <= 1'b1; end
               default: begin
                  if (txn_len > 0) begin
                     wr_busy = BUSY_CYC; txn_wr++;
                     if ((txn_start % PAGE) + txn_len > PAGE) cross_err++;
                     stop_cyc = cyc; gap_pend = 1;
                  end
                  txn_len = 0; ph = 5; ack <= 1'b1;
               end
            endcase
         end else if (active && done) begin
            active = 0;
         end
         if (active && lat > 0) begin
            lat--;
            if (lat == 0) done <= 1'b1;
         end
      end
   end
endmodule

module eeprom_page_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 9, CW = 8, PAGE = 8;
   localparam logic [6:0] DEV = 7'h50;
   localparam int WAIT0 = 40, BUSY0 = 30, BUSY1 = 60;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          op_valid [2], op_ready [2], op_read [2];
   logic [AW-1:0] op_addr [2];
   logic [CW-1:0] op_count [2], err_offset [2];
   logic          fifo_empty [2], fifo_pop [2], rd_valid [2], err [2];
   logic [7:0]    fifo_data [2], rd_data [2], bm_wdata [2], bm_rdata [2];
   logic          bm_valid [2], bm_nack [2], bm_done [2], bm_ack [2];
   logic [1:0]    bm_op [2];

   int nchk = 0, nfail = 0;
   int rd_cnt [2];
   logic [7:0] rd_buf [2][64];

   eeprom_page_seq #(.AW(AW), .CW(CW), .PAGE(PAGE), .DEV_ADDR(DEV), .POLL_MODE(0), .WR_WAIT_CYC(WAIT0)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid[0]), .op_ready(op_ready[0]), .op_read(op_read[0]),
      .op_addr(op_addr[0]), .op_count(op_count[0]), .fifo_empty(fifo_empty[0]), .fifo_data(fifo_data[0]),
      .fifo_pop(fifo_pop[0]), .rd_valid(rd_valid[0]), .rd_data(rd_data[0]), .bm_cmd_valid(bm_valid[0]),
      .bm_cmd_op(bm_op[0]), .bm_cmd_wdata(bm_wdata[0]), .bm_cmd_nack(bm_nack[0]), .bm_done(bm_done[0]),
      .bm_ack(bm_ack[0]), .bm_rdata(bm_rdata[0]), .err(err[0]), .err_offset(err_offset[0]));

   tb_eeprom_model #(.AW(AW), .PAGE(PAGE), .DEV(DEV), .BUSY_CYC(BUSY0)) u_mdl0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(bm_valid[0]), .cmd_op(bm_op[0]), .cmd_wdata(bm_wdata[0]),
      .cmd_nack(bm_nack[0]), .fifo_pop(fifo_pop[0]), .done(bm_done[0]), .ack(bm_ack[0]),
      .rdata(bm_rdata[0]), .fifo_empty(fifo_empty[0]), .fifo_data(fifo_data[0]));

   eeprom_page_seq #(.AW(AW), .CW(CW), .PAGE(PAGE), .DEV_ADDR(DEV), .POLL_MODE(1), .WR_WAIT_CYC(WAIT0)) u_dut_poll (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid[1]), .op_ready(op_ready[1]), .op_read(op_read[1]),
      .op_addr(op_addr[1]), .op_count(op_count[1]), .fifo_empty(fifo_empty[1]), .fifo_data(fifo_data[1]),
      .fifo_pop(fifo_pop[1]), .rd_valid(rd_valid[1]), .rd_data(rd_data[1]), .bm_cmd_valid(bm_valid[1]),
      .bm_cmd_op(bm_op[1]), .bm_cmd_wdata(bm_wdata[1]), .bm_cmd_nack(bm_nack[1]), .bm_done(bm_done[1]),
      .bm_ack(bm_ack[1]), .bm_rdata(bm_rdata[1]), .err(err[1]), .err_offset(err_offset[1]));

   tb_eeprom_model #(.AW(AW), .PAGE(PAGE), .DEV(DEV), .BUSY_CYC(BUSY1)) u_mdl1 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(bm_valid[1]), .cmd_op(bm_op[1]), .cmd_wdata(bm_wdata[1]),
      .cmd_nack(bm_nack[1]), .fifo_pop(fifo_pop[1]), .done(bm_done[1]), .ack(bm_ack[1]),
      .rdata(bm_rdata[1]), .fifo_empty(fifo_empty[1]), .fifo_data(fifo_data[1]));

   always @(negedge clk) begin
      for (int u = 0; u < 2; u++)
         if (rd_valid[u] && rd_cnt[u] < 64) begin
            rd_buf[u][rd_cnt[u]] = rd_data[u];
            rd_cnt[u]++;
         end
   end

   task automatic check_eq(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   task automatic do_op(int u, bit rd, int addr, int cnt);
      @(negedge clk);
      while (!op_ready[u]) @(negedge clk);
      op_read[u] = rd; op_addr[u] = AW'(addr); op_count[u] = CW'(cnt); op_valid[u] = 1'b1;
      @(negedge clk);
      op_valid[u] = 1'b0;
      @(negedge clk);
      while (!op_ready[u]) @(negedge clk);
   endtask

   task automatic fifo_cfg(int u, int seed, int lim);
      if (u == 0) begin
         u_mdl0.seed = seed; u_mdl0.push_limit = lim; u_mdl0.pushed = 0; u_mdl0.popped = 0; u_mdl0.avail = 0;
      end else begin
         u_mdl1.seed = seed; u_mdl1.push_limit = lim; u_mdl1.pushed = 0; u_mdl1.popped = 0; u_mdl1.avail = 0;
      end
   endtask

   function automatic int mem_at(int u, int a);
      return (u == 0) ? int'(u_mdl0.mem[a % (1 << AW)]) : int'(u_mdl1.mem[a % (1 << AW)]);
   endfunction

   // write then read back one region, checking data, chunking, pops and the read stream
   task automatic write_read(int u, int addr, int cnt, int seed);
      int txn0, bad, first_bad, exp_b, pops;
      txn0 = (u == 0) ? u_mdl0.txn_wr : u_mdl1.txn_wr;
      fifo_cfg(u, seed, cnt);
      do_op(u, 1'b0, addr, cnt);
      bad = 0; first_bad = -1;
      for (int k = 0; k < cnt; k++)
         if (mem_at(u, addr + k) != ((seed + k * 7) & 255)) begin
            bad++;
            if (first_bad < 0) first_bad = k;
         end
      check_eq("R1", $sformatf("write data mismatches at addr %0d cnt %0d (first %0d)", addr, cnt, first_bad), bad, 0);
      check_eq("R2", $sformatf("transactions for addr %0d cnt %0d", addr, cnt),
               ((u == 0) ? u_mdl0.txn_wr : u_mdl1.txn_wr) - txn0, ((addr % PAGE) + cnt + PAGE - 1) / PAGE);
      pops = (u == 0) ? u_mdl0.popped : u_mdl1.popped;
      check_eq("R3", "fifo pops", pops, cnt);
      rd_cnt[u] = 0;
      do_op(u, 1'b1, addr, cnt);
      check_eq("R6", "read byte count", rd_cnt[u], cnt);
      bad = 0;
      for (int k = 0; k < cnt && k < 64; k++) begin
         exp_b = (seed + k * 7) & 255;
         if (int'(rd_buf[u][k]) != exp_b) bad++;
      end
      check_eq("R7", $sformatf("read stream mismatches at addr %0d", addr), bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int n, c0, cnts [5];
      cnts = '{1, 5, 8, 9, 17};
      for (int u = 0; u < 2; u++) begin
         op_valid[u] = 1'b0; op_read[u] = 1'b0; op_addr[u] = '0; op_count[u] = '0; rd_cnt[u] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check_eq("R11", "op_ready after reset", int'(op_ready[0]), 1);
      check_eq("R11", "bm_cmd_valid after reset", int'(bm_valid[0]), 0);
      check_eq("R11", "err after reset", int'(err[0]), 0);
      check_eq("R11", "rd_valid after reset", int'(rd_valid[0]), 0);

      // sweep of start offsets within a page and counts, timeout variant
      n = 0;
      for (int a = 0; a < PAGE; a++)
         for (int ci = 0; ci < 5; ci++) begin
            write_read(0, 250 + a, cnts[ci], n * 13 + 1);
            n++;
         end
      check_eq("R2", "page crossings seen by device", u_mdl0.cross_err, 0);
      check_eq("R6", "read NACK/STOP order violations", u_mdl0.bad_nack, 0);
      check_eq("R10", "command dropped before completion", u_mdl0.proto_err, 0);
      check_eq("R4", "device busy NACKs under timeout", u_mdl0.busy_nacks, 0);
      nchk++;
      if (u_mdl0.min_gap < WAIT0) begin
         nfail++;
         $display("FAIL R4 STOP-to-START gap: actual %0d expected >= %0d", u_mdl0.min_gap, WAIT0);
      end

      // R9 zero-count operation is ignored
      c0 = u_mdl0.cmd_cnt;
      do_op(0, 1'b0, 17, 0);
      repeat (10) @(negedge clk);
      check_eq("R9", "bus commands after zero count", u_mdl0.cmd_cnt - c0, 0);
      check_eq("R9", "op_ready after zero count", int'(op_ready[0]), 1);

      // R8 NACK on the fourth data byte
      fifo_cfg(0, 99, 10);
      u_mdl0.force_nack_idx = u_mdl0.data_cnt + 3;
      do_op(0, 1'b0, 3, 10);
      u_mdl0.force_nack_idx = -1;
      check_eq("R8", "err after data NACK", int'(err[0]), 1);
      check_eq("R8", "err_offset after data NACK", int'(err_offset[0]), 3);
      check_eq("R8", "mem beyond NACK untouched", mem_at(0, 6), 8'hEE);
      repeat (BUSY0 + 20) @(negedge clk);
      write_read(0, 40, 2, 77);
      check_eq("R8", "err cleared by next operation", int'(err[0]), 0);

      // acknowledge polling variant
      write_read(1, 5, 20, 11);
      write_read(1, 0, 8, 29);
      write_read(1, 13, 3, 45);
      nchk++;
      if (u_mdl1.busy_nacks == 0) begin
         nfail++;
         $display("FAIL R5 busy NACKs while polling: actual %0d expected > 0", u_mdl1.busy_nacks);
      end
      check_eq("R5", "page crossings under polling", u_mdl1.cross_err, 0);
      check_eq("R6", "read NACK/STOP order under polling", u_mdl1.bad_nack, 0);
      check_eq("R10", "command dropped under polling", u_mdl1.proto_err, 0);
      check_eq("R8", "no error flag under polling", int'(err[1]), 0);
      summary();
   end
endmodule